// File: doc/BRIEF.md
# Packet-Atomic Readback FIFO

This block buffers readback data that arrives as fixed-size packets of four 32-bit words and hands it to a processor one word at a time. A packet is stored only as a whole: if the storage lacks room for every word of the packet, nothing of it is kept and a one-cycle drop indication is raised so that the error can be logged upstream. The packet source gets no back-pressure. A packet offered on `pkt_valid` is either taken or dropped in that same cycle, so the packet interface has no ready signal.

The processor side is a keyhole window. Each read strobe returns the word at the head of the queue and removes it. A read of an empty queue returns zero and leaves the state alone. Writes into the window are accepted on the bus but change nothing. Status pins report emptiness and the number of free entries. Storage depth defaults to 2048 entries and must be a power of two no smaller than the packet size.

Top module: `pkt_readback_fifo`

## Requirements
- R1: After reset `empty` is 1, `free_cnt` equals DEPTH, `drop_pulse` is 0 and `rd_data` is 0.
- R2: A packet offered while `free_cnt` is at least 4 is stored whole. Word k sits in `pkt_data` bits [32k+31:32k], and words are queued in the order 0, 1, 2, 3.
- R3: A packet offered while `free_cnt` is below 4 stores no word. `drop_pulse` is high in that same cycle, and no later read returns any of its words.
- R4: While `rd_stb` is high and the queue holds data, `rd_data` shows the oldest stored word. That word is removed at the clock edge, and `free_cnt` rises by one when no packet is taken in the same cycle.
- R5: A read while `empty` is high returns 0 and changes neither `empty` nor `free_cnt`.
- R6: A write strobe with any data changes neither the stored words nor `free_cnt`.
- R7: When a packet and a read arrive in the same cycle, the room check uses the occupancy before that cycle's pop. An accepted packet plus a pop changes `free_cnt` by -3. With 3 free entries the packet is dropped even though the pop frees a fourth.
- R8: Word order holds across any number of wrap-arounds of the storage, for any interleaving of packets and reads.
- R9: `empty` is high exactly when `free_cnt` equals DEPTH, and `free_cnt` always equals DEPTH minus the number of stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; empties the queue |
| pkt_valid | input | 1 | A packet is offered this cycle |
| pkt_data | input | PKT_WORDS*DATA_W | Packet words, word 0 in the low bits |
| rd_stb | input | 1 | Read of the keyhole window; pops one word |
| rd_data | output | DATA_W | Head word, or 0 when empty |
| wr_stb | input | 1 | Write to the keyhole window (no effect) |
| wr_data | input | DATA_W | Write data (ignored) |
| empty | output | 1 | No word stored |
| free_cnt | output | $clog2(DEPTH)+1 | Number of free entries |
| drop_pulse | output | 1 | The packet offered this cycle was dropped |

## Verification
The bench builds the block with DEPTH set to 16 and the default 32-bit word and four-word packet. At that depth four packets fill the storage, so the full-drop boundary can be reached directly. So can the case of three free entries plus a simultaneous pop, and many pointer wrap-arounds, all within a few hundred cycles. The default depth of 2048 uses the same pointer and counter logic with wider fields. A reference queue in the bench predicts every read value, drop and free count.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  // One cycle's decision for the queue.
  typedef struct packed {
    logic accept;  // packet is written this cycle
    logic drop;    // packet is discarded this cycle
    logic pop;     // head word is removed this cycle
  } rbf_evt_t;

endpackage

// File: rtl/rbf_occupancy.sv
module rbf_occupancy
  import rbf_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4,
  parameter int CNT_W     = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             rd_stb,
  output rbf_evt_t         evt,
  output logic             empty,
  output logic [CNT_W-1:0] free_cnt
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PKT_C   = CNT_W'(PKT_WORDS);

  logic [CNT_W-1:0] occ_q;
  logic [CNT_W-1:0] occ_d;
  logic [CNT_W-1:0] room;

  // Room is judged on the occupancy held before this cycle's pop.
  assign room = DEPTH_C - occ_q;

  always_comb begin
    evt.accept = pkt_valid && (room >= PKT_C);
    evt.drop   = pkt_valid && (room < PKT_C);
    evt.pop    = rd_stb && (occ_q != '0);
    occ_d      = occ_q;
    if (evt.accept) occ_d = occ_d + PKT_C;
    if (evt.pop)    occ_d = occ_d - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign empty    = (occ_q == '0);
  assign free_cnt = room;

  // R9: occupancy never exceeds the storage depth
  a_r9_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= DEPTH_C);

  // R5: a pop on an empty queue is never taken
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && empty && !pkt_valid) |=> empty);

endmodule

// File: rtl/rbf_store.sv
module rbf_store
  import rbf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4,
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  rbf_evt_t                    evt,
  input  logic [PKT_WORDS*DATA_W-1:0] pkt_data,
  output logic [DATA_W-1:0]           head
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] word [PKT_WORDS];
  logic [AW-1:0]     wptr_q;
  logic [AW-1:0]     rptr_q;

  // Split the packet into its words, word 0 in the low bits.
  for (genvar k = 0; k < PKT_WORDS; k++) begin : g_split
    assign word[k] = pkt_data[k*DATA_W +: DATA_W];
  end

  // Word k lands at wptr+k; the address wraps modulo DEPTH.
  always_ff @(posedge clk) begin
    if (evt.accept) begin
      for (int k = 0; k < PKT_WORDS; k++) begin
        mem[wptr_q + AW'(k)] <= word[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (evt.accept) wptr_q <= wptr_q + AW'(PKT_WORDS);
      if (evt.pop)    rptr_q <= rptr_q + AW'(1);
    end
  end

  assign head = mem[rptr_q];

  // R2: an accepted packet advances the write pointer by one packet
  a_r2_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    evt.accept |=> (wptr_q == $past(wptr_q) + AW'(PKT_WORDS)));

  // R3: a dropped packet leaves the write pointer where it was
  a_r3_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    evt.drop |=> $stable(wptr_q));

endmodule

// File: rtl/rbf_window.sv
module rbf_window #(
  parameter int DATA_W = 32
) (
  input  logic              empty,
  input  logic [DATA_W-1:0] head,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  // The window is read-only: write traffic is absorbed here.
  logic unused_wr_ok;
  assign unused_wr_ok = ^{wr_stb, wr_data};

  // Stale storage is never exposed; an empty queue reads as zero.
  assign rd_data = empty ? '0 : head;

endmodule

// File: rtl/pkt_readback_fifo.sv
module pkt_readback_fifo
  import rbf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pkt_valid,
  input  logic [PKT_WORDS*DATA_W-1:0] pkt_data,
  input  logic                        rd_stb,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        wr_stb,
  input  logic [DATA_W-1:0]           wr_data,
  output logic                        empty,
  output logic [$clog2(DEPTH):0]      free_cnt,
  output logic                        drop_pulse
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  rbf_evt_t          evt;
  logic [DATA_W-1:0] head;

  rbf_occupancy #(
    .DEPTH    (DEPTH),
    .PKT_WORDS(PKT_WORDS),
    .CNT_W    (CNT_W)
  ) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_valid(pkt_valid),
    .rd_stb   (rd_stb),
    .evt      (evt),
    .empty    (empty),
    .free_cnt (free_cnt)
  );

  rbf_store #(
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .PKT_WORDS(PKT_WORDS),
    .AW       (AW)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .pkt_data(pkt_data),
    .head    (head)
  );

  rbf_window #(
    .DATA_W(DATA_W)
  ) u_win (
    .empty  (empty),
    .head   (head),
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

  assign drop_pulse = evt.drop;

  // R2: a packet with room and no read shrinks free space by one packet
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && free_cnt >= CNT_W'(PKT_WORDS) && !rd_stb)
    |=> free_cnt == $past(free_cnt) - CNT_W'(PKT_WORDS));

  // R3: a dropped packet leaves free space unchanged when nothing is read
  a_r3_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pulse && !rd_stb) |=> $stable(free_cnt));

  // R4: a lone read of a non-empty queue frees exactly one entry
  a_r4_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !empty && !pkt_valid)
    |=> free_cnt == $past(free_cnt) + CNT_W'(1));

  // R7: a packet taken together with a pop moves free space by one packet less one
  a_r7_joint: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && rd_stb && !empty && free_cnt >= CNT_W'(PKT_WORDS))
    |=> free_cnt == $past(free_cnt) - CNT_W'(PKT_WORDS) + CNT_W'(1));

  // R6: a write alone changes no state visible at the ports
  a_r6_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb && !pkt_valid) |=> $stable(free_cnt));

  // R9: the empty flag and the free count agree
  a_r9_empty_free: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (free_cnt == CNT_W'(DEPTH)));

endmodule

// File: tb/pkt_readback_fifo_bench.sv
`timescale 1ns/1ps
module pkt_readback_fifo_bench;

  localparam int DEPTH = 16;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pkt_valid;
  logic [127:0]  pkt_data;
  logic          rd_stb;
  logic [DW-1:0] rd_data;
  logic          wr_stb;
  logic [DW-1:0] wr_data;
  logic          empty;
  logic [4:0]    free_cnt;
  logic          drop_pulse;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;
  logic [DW-1:0] mq[$];

  always #5 clk = ~clk;

  pkt_readback_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .PKT_WORDS(4)) u_pkt_readback_fifo (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data),
    .empty(empty), .free_cnt(free_cnt), .drop_pulse(drop_pulse)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkpkt(input logic [DW-1:0] base);
    return {base + 32'd3, base + 32'd2, base + 32'd1, base};
  endfunction

  // One cycle: inputs driven after a falling edge, outputs compared to the reference queue.
  task automatic step(input logic pv, input logic [127:0] pd, input logic rd,
                      input logic wr, input logic [DW-1:0] wd, input string tag);
    bit room;
    logic [DW-1:0] exp_rd;
    pkt_valid = pv; pkt_data = pd; rd_stb = rd; wr_stb = wr; wr_data = wd;
    #1;
    room   = (DEPTH - mq.size()) >= 4;
    exp_rd = (mq.size() != 0) ? mq[0] : '0;
    if (rd) chk(rd_data == exp_rd, tag, "rd_data", rd_data, exp_rd);
    chk(drop_pulse == (pv && !room), tag, "drop_pulse", 32'(drop_pulse), 32'(pv && !room));
    if (rd && mq.size() != 0) void'(mq.pop_front());
    if (pv && room) for (int k = 0; k < 4; k++) mq.push_back(pd[k*DW +: DW]);
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 0; rd_stb = 0; wr_stb = 0;
    chk(free_cnt == 5'(DEPTH - mq.size()), "R9", "free_cnt", 32'(free_cnt), 32'(DEPTH - mq.size()));
    chk(empty == (mq.size() == 0), "R9", "empty", 32'(empty), 32'(mq.size() == 0));
  endtask

  task automatic drain(input string tag);
    while (mq.size() != 0) step(0, '0, 1, 0, '0, tag);
  endtask

  task automatic t_reset();
    #1;
    chk(empty == 1'b1, "R1", "empty", 32'(empty), 1);
    chk(free_cnt == 5'(DEPTH), "R1", "free_cnt", 32'(free_cnt), DEPTH);
    chk(drop_pulse == 1'b0, "R1", "drop_pulse", 32'(drop_pulse), 0);
    chk(rd_data == '0, "R1", "rd_data", rd_data, 0);
  endtask

  task automatic t_basic();
    step(1, mkpkt(32'hA000_0000), 0, 0, '0, "R2");
    drain("R4");
  endtask

  task automatic t_fill_drop();
    for (int p = 0; p < 4; p++) step(1, mkpkt(32'hB000_0000 + 32'(p*16)), 0, 0, '0, "R2");
    step(1, mkpkt(32'hDEAD_0000), 0, 0, '0, "R3");
    step(0, '0, 1, 0, '0, "R4");
    step(1, mkpkt(32'hDEAD_1000), 0, 0, '0, "R3");
    drain("R3");
  endtask

  task automatic t_empty_read();
    step(0, '0, 1, 0, '0, "R5");
    step(0, '0, 1, 0, '0, "R5");
    step(1, mkpkt(32'hC000_0000), 0, 0, '0, "R5");
    drain("R5");
  endtask

  task automatic t_write_ignored();
    step(1, mkpkt(32'h1234_0000), 0, 0, '0, "R6");
    step(0, '0, 0, 1, 32'hFFFF_FFFF, "R6");
    step(0, '0, 0, 1, 32'h5A5A_5A5A, "R6");
    step(0, '0, 1, 1, 32'h0BAD_0BAD, "R6");
    drain("R6");
    step(0, '0, 0, 1, 32'h7777_7777, "R6");
  endtask

  task automatic t_joint();
    for (int p = 0; p < 4; p++) step(1, mkpkt(32'hE000_0000 + 32'(p*16)), 0, 0, '0, "R7");
    for (int r = 0; r < 3; r++) step(0, '0, 1, 0, '0, "R7");
    step(1, mkpkt(32'hDEAD_2000), 1, 0, '0, "R7");  // 3 free before pop: dropped
    step(1, mkpkt(32'hE100_0000), 1, 0, '0, "R7");  // 4 free: taken with pop
    drain("R7");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 12; i++) begin
      step(1, mkpkt(32'hF000_0000 + 32'(i*4)), (i % 3) != 0, 0, '0, "R8");
      step(0, '0, 1, 0, '0, "R8");
      step(0, '0, 1, 0, '0, "R8");
    end
    drain("R8");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; pkt_valid = 0; pkt_data = '0; rd_stb = 0; wr_stb = 0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    @(negedge clk);
    t_basic();
    t_fill_drop();
    t_empty_read();
    t_write_ignored();
    t_joint();
    t_wrap();
    finish_run();
  end

endmodule